// File: doc/BRIEF.md
# SDRAM Bank Timing Guard

This block watches the command lines of a four-bank double-data-rate SDRAM on every rising clock edge. It decodes activate, precharge, read and write from the chip-select, row-strobe, column-strobe and write-enable pins. It keeps an open or idle flag for each bank, and it measures cycle distances between commands so that it can report any command that breaks a bank spacing rule.

Each rule has a compile-time minimum cycle count. When a command breaks one or more rules, the block raises a one-cycle violation pulse in the cycle after that command, together with a code that names the broken rule. A flagged command still updates the tracked state exactly as the memory would, so the guard stays aligned with the bus. The block is meant to sit beside a memory controller in simulation or in silicon as a passive monitor.

Top module: `sdram_bank_guard`

## Requirements
- R1: While reset is held, and in the first cycle after it, all four `bank_open` bits are 0, `viol` is 0 and `viol_code` is 0.
- R2: An activate (cs_n,ras_n,cas_n,we_n = 0,0,1,1) opens the bank selected by `bank` (0..3 map to `bank_open[0]`..`bank_open[3]`). An activate to a bank that is already open is flagged with code 1.
- R3: A precharge (0,0,1,0) with `ap`=0 closes only the selected bank. With `ap`=1 it closes all four banks, and `bank` has no effect. A precharge to an idle bank is legal, leaves that bank idle and does not restart its precharge timer.
- R4: Deselect (cs_n=1, any value on the other pins) and no-operation (0,1,1,1) change no bank state and raise no flag.
- R5: An activate fewer than T_RP cycles after the precharge that closed that bank is flagged with code 2.
- R6: An activate fewer than T_RC cycles after the previous activate to the same bank is flagged with code 3.
- R7: An activate to a bank other than the one in the last activate, fewer than T_RRD cycles after that activate, is flagged with code 4.
- R8: A read (0,1,0,1) or write (0,1,0,0) to an idle bank is flagged with code 5.
- R9: A read or write fewer than T_RCD cycles after the activate of its bank is flagged with code 6.
- R10: A precharge that closes an open bank fewer than T_RAS cycles after that bank's activate is flagged with code 7.
- R11: A precharge that closes an open bank fewer than T_WR cycles after a write to that bank is flagged with code 8.
- R12: All timers start saturated at reset, so no timing rule flags the first command after reset. When several rules fail together, the lowest code is reported. `viol` is high for exactly the one cycle after the offending command, and `viol_code` is 0 whenever `viol` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | 2 | Bank address of the command |
| ap | input | 1 | Address bit that selects all-bank precharge |
| bank_open | output | 4 | One bit per bank; 1 means open |
| viol | output | 1 | One-cycle pulse after a rule-breaking command |
| viol_code | output | 4 | Lowest failing rule code (1..8), 0 when no violation |

## Verification
The embedded assertions check on every cycle how single commands affect state: an activate opens its bank, an all-bank precharge leaves nothing open, idle cycles leave the flags and the pulse quiet, a column command to an idle bank produces code 5, and the pulse and code agree. The timing rules depend on distances of several cycles and on which rule wins a tie. Only the bench's gap sweeps show these, because it computes for each spacing whether the result lies below or at the limit and which code should appear. The sweeps include all-bank precharge with a mismatched bank field and several rules that fail together.

// File: rtl/sdram_bank_guard.sv
module sdram_bank_guard #(
  parameter int T_RP  = 3,
  parameter int T_RCD = 3,
  parameter int T_RRD = 2,
  parameter int T_WR  = 3,
  parameter int T_RAS = 6,
  parameter int T_RC  = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic [1:0] bank,
  input  logic       ap,
  output logic [3:0] bank_open,
  output logic       viol,
  output logic [3:0] viol_code
);
  localparam int M1   = (T_RP  > T_RCD) ? T_RP  : T_RCD;
  localparam int M2   = (T_RRD > T_WR)  ? T_RRD : T_WR;
  localparam int M3   = (T_RAS > T_RC)  ? T_RAS : T_RC;
  localparam int M12  = (M1 > M2) ? M1 : M2;
  localparam int TMAX = (M12 > M3) ? M12 : M3;
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] SAT   = CW'(TMAX);
  localparam logic [CW-1:0] L_RP  = CW'(T_RP);
  localparam logic [CW-1:0] L_RCD = CW'(T_RCD);
  localparam logic [CW-1:0] L_RRD = CW'(T_RRD);
  localparam logic [CW-1:0] L_WR  = CW'(T_WR);
  localparam logic [CW-1:0] L_RAS = CW'(T_RAS);
  localparam logic [CW-1:0] L_RC  = CW'(T_RC);

  logic [CW-1:0] act_cnt [4];
  logic [CW-1:0] pre_cnt [4];
  logic [CW-1:0] wr_cnt  [4];
  logic [CW-1:0] rrd_cnt;
  logic [1:0]    last_bk;
  logic [3:0]    open_q;
  logic          viol_q;
  logic [3:0]    code_q;

  wire sel    = ~cs_n;
  wire is_act = sel & ~ras_n &  cas_n &  we_n;
  wire is_pre = sel & ~ras_n &  cas_n & ~we_n;
  wire is_rd  = sel &  ras_n & ~cas_n &  we_n;
  wire is_wr  = sel &  ras_n & ~cas_n & ~we_n;
  wire is_col = is_rd | is_wr;

  wire [3:0] pre_mask  = ap ? 4'hF : (4'b0001 << bank);
  wire [3:0] pre_close = {4{is_pre}} & pre_mask & open_q;

  logic [3:0] ras_short, wr_short;
  always_comb begin
    for (int i = 0; i < 4; i++) begin
      ras_short[i] = act_cnt[i] < L_RAS;
      wr_short[i]  = wr_cnt[i]  < L_WR;
    end
  end

  logic [8:1] err;
  assign err[1] = is_act & open_q[bank];
  assign err[2] = is_act & (pre_cnt[bank] < L_RP);
  assign err[3] = is_act & (act_cnt[bank] < L_RC);
  assign err[4] = is_act & (bank != last_bk) & (rrd_cnt < L_RRD);
  assign err[5] = is_col & ~open_q[bank];
  assign err[6] = is_col & (act_cnt[bank] < L_RCD);
  assign err[7] = |(pre_close & ras_short);
  assign err[8] = |(pre_close & wr_short);

  logic [3:0] code_d;
  always_comb begin
    code_d = 4'd0;
    for (int k = 8; k >= 1; k--)
      if (err[k]) code_d = 4'(k);
  end

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
    return (c == SAT) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        act_cnt[i] <= SAT;
        pre_cnt[i] <= SAT;
        wr_cnt[i]  <= SAT;
      end
      rrd_cnt <= SAT;
      last_bk <= 2'd0;
      open_q  <= 4'd0;
      viol_q  <= 1'b0;
      code_q  <= 4'd0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        act_cnt[i] <= (is_act && bank == i[1:0]) ? CW'(1) : bump(act_cnt[i]);
        pre_cnt[i] <= pre_close[i]               ? CW'(1) : bump(pre_cnt[i]);
        wr_cnt[i]  <= (is_wr && bank == i[1:0])  ? CW'(1) : bump(wr_cnt[i]);
      end
      rrd_cnt <= is_act ? CW'(1) : bump(rrd_cnt);
      if (is_act) last_bk <= bank;
      open_q <= (open_q & ~pre_close) | ({4{is_act}} & (4'b0001 << bank));
      viol_q <= |err;
      code_q <= code_d;
    end
  end

  assign bank_open = open_q;
  assign viol      = viol_q;
  assign viol_code = code_q;

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n) is_act |=> bank_open[$past(bank)]); // R2
  AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n) (is_pre && ap) |=> (bank_open == 4'd0)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (cs_n || (ras_n && cas_n && we_n)) |=> ($stable(bank_open) && !viol)); // R4
  AST_COL_IDLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (is_col && !bank_open[bank]) |=> (viol && viol_code == 4'd5)); // R8
  AST_CODE_PAIR: assert property (@(posedge clk) disable iff (!rst_n) viol == (viol_code != 4'd0)); // R12
endmodule

// File: tb/sdram_bank_guard_test.sv
`timescale 1ns/1ps
module sdram_bank_guard_test;
  localparam int T_RP = 3, T_RCD = 3, T_RRD = 2, T_WR = 3, T_RAS = 6, T_RC = 11;
  localparam logic [3:0] C_ACT = 4'b0011, C_PRE = 4'b0010, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_NOP = 4'b0111, C_DES = 4'b1111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, ap;
  logic [1:0] bank;
  logic [3:0] bank_open, viol_code;
  logic viol;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  sdram_bank_guard #(.T_RP(T_RP), .T_RCD(T_RCD), .T_RRD(T_RRD), .T_WR(T_WR),
                     .T_RAS(T_RAS), .T_RC(T_RC)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .bank(bank), .ap(ap), .bank_open(bank_open), .viol(viol), .viol_code(viol_code));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] p, input logic [1:0] b, input logic a);
    {cs_n, ras_n, cas_n, we_n} = p; bank = b; ap = a;
  endtask

  task automatic issue(input logic [3:0] p, input logic [1:0] b, input logic a,
                       input int exp, input string req);
    drive(p, b, a);
    @(posedge clk); @(negedge clk);
    drive(C_NOP, 2'd0, 1'b0);
    chk(req, viol_code, exp);
    chk(req, viol, exp != 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic do_reset();
    drive(C_NOP, 2'd0, 1'b0);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1", bank_open, 0); chk("R1", viol, 0); chk("R1", viol_code, 0);

    // R8 column command to idle bank, every bank, read and write
    for (int b = 0; b < 4; b++) begin
      issue(C_RD, 2'(b), 1'b0, 5, "R8");
      issue(C_WR, 2'(b), 1'b0, 5, "R8");
    end

    // R2 / R12 open every bank, first activate after reset is not timed
    do_reset();
    for (int b = 0; b < 4; b++) begin
      issue(C_ACT, 2'(b), 1'b0, 0, "R12");
      chk("R2", bank_open, (1 << (b + 1)) - 1);
      idle(T_RRD - 1);
    end
    chk("R12", viol, 0);
    idle(T_RC);
    issue(C_ACT, 2'd0, 1'b0, 1, "R2");

    // R4 deselect with every pattern, and no-operation
    for (int p = 0; p < 8; p++) begin
      issue({1'b1, 3'(p)}, 2'(p), p[0], 0, "R4");
      chk("R4", bank_open, 4'hF);
    end
    issue(C_NOP, 2'd1, 1'b1, 0, "R4");
    chk("R4", bank_open, 4'hF);

    // R3 single precharge, idle precharge, all-bank precharge
    idle(T_RAS);
    issue(C_PRE, 2'd2, 1'b0, 0, "R3");
    chk("R3", bank_open, 4'b1011);
    issue(C_PRE, 2'd2, 1'b0, 0, "R3");
    chk("R3", bank_open, 4'b1011);
    issue(C_PRE, 2'd2, 1'b1, 0, "R3");
    chk("R3", bank_open, 4'b0000);

    // R5 precharge-to-activate sweep (tRC may also fail; lower code wins)
    for (int d = 1; d <= T_RP + 1; d++) begin
      do_reset();
      issue(C_ACT, 2'd0, 1'b0, 0, "R5");
      idle(T_RAS - 1);
      issue(C_PRE, 2'd0, 1'b0, 0, "R5");
      idle(d - 1);
      issue(C_ACT, 2'd0, 1'b0, (d < T_RP) ? 2 : ((T_RAS + d < T_RC) ? 3 : 0), "R5");
    end

    // R6 activate-to-activate same bank sweep
    for (int g = T_RAS + T_RP; g <= T_RC + 1; g++) begin
      do_reset();
      issue(C_ACT, 2'd1, 1'b0, 0, "R6");
      idle(T_RAS - 1);
      issue(C_PRE, 2'd1, 1'b0, 0, "R6");
      idle(g - T_RAS - 1);
      issue(C_ACT, 2'd1, 1'b0, (g < T_RC) ? 3 : 0, "R6");
    end

    // R7 bank-to-bank activate sweep
    for (int d = 1; d <= T_RRD + 1; d++) begin
      do_reset();
      issue(C_ACT, 2'd0, 1'b0, 0, "R7");
      idle(d - 1);
      issue(C_ACT, 2'd3, 1'b0, (d < T_RRD) ? 4 : 0, "R7");
    end

    // R9 activate-to-column sweep, read and write
    for (int w = 0; w < 2; w++)
      for (int d = 1; d <= T_RCD + 1; d++) begin
        do_reset();
        issue(C_ACT, 2'd2, 1'b0, 0, "R9");
        idle(d - 1);
        issue(w ? C_WR : C_RD, 2'd2, 1'b0, (d < T_RCD) ? 6 : 0, "R9");
      end

    // R10 activate-to-precharge sweep
    for (int d = 1; d <= T_RAS + 1; d++) begin
      do_reset();
      issue(C_ACT, 2'd1, 1'b0, 0, "R10");
      idle(d - 1);
      issue(C_PRE, 2'd1, 1'b0, (d < T_RAS) ? 7 : 0, "R10");
      chk("R10", bank_open, 0);
    end

    // R11 write recovery sweep, single and all-bank precharge
    for (int a = 0; a < 2; a++)
      for (int d = 1; d <= T_WR + 1; d++) begin
        do_reset();
        issue(C_ACT, 2'd3, 1'b0, 0, "R11");
        idle(T_RAS - 1);
        issue(C_WR, 2'd3, 1'b0, 0, "R11");
        idle(d - 1);
        issue(C_PRE, a ? 2'd0 : 2'd3, a[0], (d < T_WR) ? 8 : 0, "R11");
      end

    // R12 priority: tRAS and tWR together report 7; open and tRRD together report 1
    do_reset();
    issue(C_ACT, 2'd0, 1'b0, 0, "R12");
    idle(T_RCD - 1);
    issue(C_WR, 2'd0, 1'b0, 0, "R12");
    issue(C_PRE, 2'd0, 1'b0, 7, "R12");
    do_reset();
    issue(C_ACT, 2'd0, 1'b0, 0, "R12");
    issue(C_ACT, 2'd1, 1'b0, 4, "R12");
    issue(C_ACT, 2'd0, 1'b0, 1, "R12");
    idle(1);
    chk("R12", viol, 0); chk("R12", viol_code, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end
endmodule